// File: doc/BRIEF.md
# Segmented Operand Address Generator

This block forms the memory address of one data operand in a 16-bit segmented machine. A request names up to three components: a base register (the general one or the frame one), an index register (the source one or the destination one) and an immediate displacement of 8 or 16 bits. Any of the three may be left out. The block adds the components it is given into a 16-bit offset. It then picks a segment register and forms a 20-bit physical address: the segment value shifted left by four, plus the offset.

A request with no base and no index and only a displacement is direct addressing, and its offset is the displacement alone. Results come out of a register stage one cycle after the request, with a one-cycle valid strobe. The surrounding pipeline supplies the current register and segment values with each request and uses the results to drive the memory access.

Top module: `seg_addr_gen`

## Requirements
- R1: While rst_n is low, out_valid, out_ea and out_pa are all zero.
- R2: out_valid is high in exactly the cycle after a cycle in which in_valid was sampled high, and low otherwise.
- R3: out_ea is the sum, modulo 2^16, of the selected components. base_sel codes are 0 none, 1 general base, 2 frame base and 3 none. idx_sel codes are 0 none, 1 source index, 2 destination index and 3 none. disp_sel codes are 0 none, 1 short, 2 long and 3 none. An absent component adds zero.
- R4: A short displacement (disp_sel 1) uses disp[7:0] sign-extended to 16 bits. A long one (disp_sel 2) uses all of disp.
- R5: With no base and no index and disp_sel 2, out_ea equals disp exactly.
- R6: With ovr_en low, the segment is the data segment, except that it is the stack segment when base_sel is 2. With ovr_en high, ovr_seg picks the segment: 0 extra, 1 code, 2 stack, 3 data.
- R7: out_pa equals (segment × 16 + out_ea) modulo 2^20. For example, segment 0200h with offset 1234h gives 03234h.
- R8: In a cycle after in_valid was sampled low, out_ea and out_pa keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| base_sel | input | 2 | Base component select (R3 codes) |
| idx_sel | input | 2 | Index component select (R3 codes) |
| disp_sel | input | 2 | Displacement select (R3 codes) |
| disp | input | 16 | Displacement value |
| base_gen | input | 16 | General base register value |
| base_frame | input | 16 | Frame base register value |
| idx_src | input | 16 | Source index register value |
| idx_dst | input | 16 | Destination index register value |
| seg_extra | input | 16 | Extra segment value |
| seg_code | input | 16 | Code segment value |
| seg_stack | input | 16 | Stack segment value |
| seg_data | input | 16 | Data segment value |
| ovr_en | input | 1 | Segment override enable |
| ovr_seg | input | 2 | Override segment code (R6) |
| out_valid | output | 1 | Result strobe |
| out_ea | output | 16 | Effective offset |
| out_pa | output | 20 | Physical address |

## Verification
The properties assume that every selector input is a known value whenever in_valid is high. They also assume that reset is held for at least one clock edge before the first request. The stimulus therefore starts with rst_n and in_valid low, and drives every input to a defined value on the falling edge before each request. Between requests it drops in_valid and changes the selector and register inputs, so that the hold property is tested against moving inputs and not against quiet ones.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;
   typedef enum logic [1:0] {
      BASE_NONE  = 2'd0,
      BASE_GEN   = 2'd1,
      BASE_FRAME = 2'd2,
      BASE_RSVD  = 2'd3
   } base_sel_e;

   typedef enum logic [1:0] {
      IDX_NONE = 2'd0,
      IDX_SRC  = 2'd1,
      IDX_DST  = 2'd2,
      IDX_RSVD = 2'd3
   } idx_sel_e;

   typedef enum logic [1:0] {
      DISP_NONE  = 2'd0,
      DISP_SHORT = 2'd1,
      DISP_LONG  = 2'd2,
      DISP_RSVD  = 2'd3
   } disp_sel_e;

   typedef enum logic [1:0] {
      SEG_EXTRA = 2'd0,
      SEG_CODE  = 2'd1,
      SEG_STACK = 2'd2,
      SEG_DATA  = 2'd3
   } seg_code_e;

   localparam int SHORT_DISP_W = 8;
endpackage

// File: rtl/agu_offset_sum.sv
module agu_offset_sum
   import seg_agu_pkg::*;
#(
   parameter int  OFF_W        = 16,
   parameter bit  SHORT_SIGNED = 1'b1
) (
   input  logic [1:0]       base_sel,
   input  logic [1:0]       idx_sel,
   input  logic [1:0]       disp_sel,
   input  logic [OFF_W-1:0] disp,
   input  logic [OFF_W-1:0] base_gen,
   input  logic [OFF_W-1:0] base_frame,
   input  logic [OFF_W-1:0] idx_src,
   input  logic [OFF_W-1:0] idx_dst,
   output logic [OFF_W-1:0] ea
);
   localparam int EXT_W = OFF_W - SHORT_DISP_W;

   logic [OFF_W-1:0] base_term;
   logic [OFF_W-1:0] idx_term;
   logic [OFF_W-1:0] disp_term;
   logic [OFF_W-1:0] short_ext;

   generate
      if (SHORT_SIGNED) begin : g_sext
         assign short_ext = {{EXT_W{disp[SHORT_DISP_W-1]}}, disp[SHORT_DISP_W-1:0]};
      end else begin : g_zext
         assign short_ext = {{EXT_W{1'b0}}, disp[SHORT_DISP_W-1:0]};
      end
   endgenerate

   always_comb begin
      unique case (base_sel)
         BASE_GEN:   base_term = base_gen;
         BASE_FRAME: base_term = base_frame;
         default:    base_term = '0;
      endcase
      unique case (idx_sel)
         IDX_SRC: idx_term = idx_src;
         IDX_DST: idx_term = idx_dst;
         default: idx_term = '0;
      endcase
      unique case (disp_sel)
         DISP_SHORT: disp_term = short_ext;
         DISP_LONG:  disp_term = disp;
         default:    disp_term = '0;
      endcase
   end

   assign ea = base_term + idx_term + disp_term;
endmodule

// File: rtl/agu_seg_pick.sv
module agu_seg_pick
   import seg_agu_pkg::*;
#(
   parameter int SEG_W = 16
) (
   input  logic [1:0]       base_sel,
   input  logic             ovr_en,
   input  logic [1:0]       ovr_seg,
   input  logic [SEG_W-1:0] seg_extra,
   input  logic [SEG_W-1:0] seg_code,
   input  logic [SEG_W-1:0] seg_stack,
   input  logic [SEG_W-1:0] seg_data,
   output logic [SEG_W-1:0] seg_val
);
   logic [1:0] pick;

   always_comb begin
      if (ovr_en)
         pick = ovr_seg;
      else if (base_sel == BASE_FRAME)
         pick = SEG_STACK;
      else
         pick = SEG_DATA;

      unique case (pick)
         SEG_EXTRA: seg_val = seg_extra;
         SEG_CODE:  seg_val = seg_code;
         SEG_STACK: seg_val = seg_stack;
         default:   seg_val = seg_data;
      endcase
   end
endmodule

// File: rtl/agu_pa_form.sv
module agu_pa_form #(
   parameter int OFF_W     = 16,
   parameter int SEG_SHIFT = 4,
   parameter int PA_W      = OFF_W + SEG_SHIFT
) (
   input  logic [OFF_W-1:0] seg_val,
   input  logic [OFF_W-1:0] ea,
   output logic [PA_W-1:0]  pa
);
   logic [PA_W-1:0] seg_scaled;
   logic [PA_W-1:0] ea_wide;

   assign seg_scaled = {seg_val, {SEG_SHIFT{1'b0}}};
   assign ea_wide    = {{SEG_SHIFT{1'b0}}, ea};
   assign pa         = seg_scaled + ea_wide;
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
   import seg_agu_pkg::*;
#(
   parameter int OFF_W        = 16,
   parameter int SEG_SHIFT    = 4,
   parameter bit SHORT_SIGNED = 1'b1,
   parameter int PA_W         = OFF_W + SEG_SHIFT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [1:0]       base_sel,
   input  logic [1:0]       idx_sel,
   input  logic [1:0]       disp_sel,
   input  logic [OFF_W-1:0] disp,
   input  logic [OFF_W-1:0] base_gen,
   input  logic [OFF_W-1:0] base_frame,
   input  logic [OFF_W-1:0] idx_src,
   input  logic [OFF_W-1:0] idx_dst,
   input  logic [OFF_W-1:0] seg_extra,
   input  logic [OFF_W-1:0] seg_code,
   input  logic [OFF_W-1:0] seg_stack,
   input  logic [OFF_W-1:0] seg_data,
   input  logic             ovr_en,
   input  logic [1:0]       ovr_seg,
   output logic             out_valid,
   output logic [OFF_W-1:0] out_ea,
   output logic [PA_W-1:0]  out_pa
);
   generate
      if (OFF_W <= SHORT_DISP_W) begin : g_bad_off_w
         $error("seg_addr_gen: OFF_W must exceed the short displacement width");
      end
      if (SEG_SHIFT < 1) begin : g_bad_shift
         $error("seg_addr_gen: SEG_SHIFT must be at least 1");
      end
      if (PA_W != OFF_W + SEG_SHIFT) begin : g_bad_pa_w
         $error("seg_addr_gen: PA_W must equal OFF_W + SEG_SHIFT");
      end
   endgenerate

   logic [OFF_W-1:0] ea_c;
   logic [OFF_W-1:0] seg_c;
   logic [PA_W-1:0]  pa_c;

   agu_offset_sum #(.OFF_W(OFF_W), .SHORT_SIGNED(SHORT_SIGNED)) u_sum (
      .base_sel   (base_sel),
      .idx_sel    (idx_sel),
      .disp_sel   (disp_sel),
      .disp       (disp),
      .base_gen   (base_gen),
      .base_frame (base_frame),
      .idx_src    (idx_src),
      .idx_dst    (idx_dst),
      .ea         (ea_c)
   );

   agu_seg_pick #(.SEG_W(OFF_W)) u_seg (
      .base_sel  (base_sel),
      .ovr_en    (ovr_en),
      .ovr_seg   (ovr_seg),
      .seg_extra (seg_extra),
      .seg_code  (seg_code),
      .seg_stack (seg_stack),
      .seg_data  (seg_data),
      .seg_val   (seg_c)
   );

   agu_pa_form #(.OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT), .PA_W(PA_W)) u_pa (
      .seg_val (seg_c),
      .ea      (ea_c),
      .pa      (pa_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_ea    <= '0;
         out_pa    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_ea <= ea_c;
            out_pa <= pa_c;
         end
      end
   end
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
   parameter int OFF_W = 16,
   parameter int PA_W  = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [1:0]       base_sel,
   input logic [1:0]       idx_sel,
   input logic [1:0]       disp_sel,
   input logic [OFF_W-1:0] disp,
   input logic             out_valid,
   input logic [OFF_W-1:0] out_ea,
   input logic [PA_W-1:0]  out_pa
);
   // R1: reset clears the result strobe
   a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !out_valid);

   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_ea) && $stable(out_pa)));

   a_r5_direct_offset: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && base_sel == 2'd0 && idx_sel == 2'd0 && disp_sel == 2'd2)
      |=> (out_ea == $past(disp)));

   a_r4_short_sign: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && base_sel == 2'd0 && idx_sel == 2'd0 && disp_sel == 2'd1)
      |=> (out_ea[OFF_W-1:8] == {(OFF_W-8){$past(disp[7])}}));
endmodule

bind seg_addr_gen seg_addr_gen_chk #(.OFF_W(OFF_W), .PA_W(PA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .base_sel  (base_sel),
   .idx_sel   (idx_sel),
   .disp_sel  (disp_sel),
   .disp      (disp),
   .out_valid (out_valid),
   .out_ea    (out_ea),
   .out_pa    (out_pa)
);

// File: tb/seg_addr_gen_tb.sv
module seg_addr_gen_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  base_sel = 2'd0;
   logic [1:0]  idx_sel = 2'd0;
   logic [1:0]  disp_sel = 2'd0;
   logic [15:0] disp = 16'h0;
   logic [15:0] base_gen = 16'h0;
   logic [15:0] base_frame = 16'h0;
   logic [15:0] idx_src = 16'h0;
   logic [15:0] idx_dst = 16'h0;
   logic [15:0] seg_extra = 16'h0;
   logic [15:0] seg_code = 16'h0;
   logic [15:0] seg_stack = 16'h0;
   logic [15:0] seg_data = 16'h0;
   logic        ovr_en = 1'b0;
   logic [1:0]  ovr_seg = 2'd0;
   logic        out_valid;
   logic [15:0] out_ea;
   logic [19:0] out_pa;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   seg_addr_gen u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .base_sel(base_sel), .idx_sel(idx_sel), .disp_sel(disp_sel), .disp(disp),
      .base_gen(base_gen), .base_frame(base_frame), .idx_src(idx_src), .idx_dst(idx_dst),
      .seg_extra(seg_extra), .seg_code(seg_code), .seg_stack(seg_stack), .seg_data(seg_data),
      .ovr_en(ovr_en), .ovr_seg(ovr_seg),
      .out_valid(out_valid), .out_ea(out_ea), .out_pa(out_pa)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] model_ea();
      logic [15:0] s = 16'h0;
      if (base_sel == 2'd1) s += base_gen;
      if (base_sel == 2'd2) s += base_frame;
      if (idx_sel == 2'd1) s += idx_src;
      if (idx_sel == 2'd2) s += idx_dst;
      if (disp_sel == 2'd1) s += {{8{disp[7]}}, disp[7:0]};
      if (disp_sel == 2'd2) s += disp;
      return s;
   endfunction

   function automatic logic [15:0] model_seg();
      logic [1:0] c;
      c = ovr_en ? ovr_seg : ((base_sel == 2'd2) ? 2'd2 : 2'd3);
      case (c)
         2'd0: return seg_extra;
         2'd1: return seg_code;
         2'd2: return seg_stack;
         default: return seg_data;
      endcase
   endfunction

   // drive current inputs as one request, check results one cycle later
   task automatic issue(input string tag);
      logic [15:0] e_ea;
      logic [19:0] e_pa;
      e_ea = model_ea();
      e_pa = ({4'h0, model_seg()} << 4) + {4'h0, e_ea};
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check({tag, " R2 valid"}, {31'd0, out_valid}, 32'd1);
      check({tag, " R3 ea"}, {16'd0, out_ea}, {16'd0, e_ea});
      check({tag, " R7 pa"}, {12'd0, out_pa}, {12'd0, e_pa});
   endtask

   task automatic t_reset();
      check("R1 valid", {31'd0, out_valid}, 32'd0);
      check("R1 ea", {16'd0, out_ea}, 32'd0);
      check("R1 pa", {12'd0, out_pa}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R2 idle after reset", {31'd0, out_valid}, 32'd0);
   endtask

   task automatic t_direct();
      base_sel = 2'd0; idx_sel = 2'd0; disp_sel = 2'd2; disp = 16'h1234;
      seg_data = 16'h0200; ovr_en = 1'b0;
      issue("R5 direct");
      check("R5 direct ea", {16'd0, out_ea}, 32'h1234);
      check("R7 example pa", {12'd0, out_pa}, 32'h03234);
      @(negedge clk);
      check("R2 single pulse", {31'd0, out_valid}, 32'd0);
   endtask

   task automatic t_short_disp();
      base_sel = 2'd0; idx_sel = 2'd0; disp_sel = 2'd1; disp = 16'h3480;
      issue("R4 short neg");
      check("R4 sign ext", {16'd0, out_ea}, 32'hFF80);
      disp = 16'hAA7F;
      issue("R4 short pos");
      check("R4 zero upper", {16'd0, out_ea}, 32'h007F);
      base_sel = 2'd1; base_gen = 16'h0100; disp = 16'h00FE;
      issue("R4 base plus neg short");
      check("R4 base-2", {16'd0, out_ea}, 32'h00FE);
   endtask

   task automatic t_combos();
      base_gen = 16'h1000; base_frame = 16'h2000; idx_src = 16'h0030; idx_dst = 16'h0400;
      disp = 16'h0005; seg_data = 16'h1111; seg_stack = 16'h2222;
      for (int b = 0; b < 4; b++) begin
         for (int i = 0; i < 4; i++) begin
            base_sel = b[1:0]; idx_sel = i[1:0]; disp_sel = 2'd2;
            issue("R3 combo");
         end
      end
      base_sel = 2'd3; idx_sel = 2'd3; disp_sel = 2'd3;
      issue("R3 reserved");
      check("R3 reserved none", {16'd0, out_ea}, 32'h0);
   endtask

   task automatic t_segments();
      seg_extra = 16'hA000; seg_code = 16'hB000; seg_stack = 16'hC000; seg_data = 16'hD000;
      base_sel = 2'd2; idx_sel = 2'd0; disp_sel = 2'd0; base_frame = 16'h0010; ovr_en = 1'b0;
      issue("R6 frame default");
      check("R6 stack seg", {12'd0, out_pa}, 32'hC0010);
      base_sel = 2'd1; base_gen = 16'h0010;
      issue("R6 general default");
      check("R6 data seg", {12'd0, out_pa}, 32'hD0010);
      ovr_en = 1'b1;
      for (int s = 0; s < 4; s++) begin
         ovr_seg = s[1:0];
         issue("R6 override");
      end
      base_sel = 2'd2; ovr_seg = 2'd0;
      issue("R6 override beats frame");
      check("R6 extra seg", {12'd0, out_pa}, 32'hA0010);
      ovr_en = 1'b0;
   endtask

   task automatic t_wrap();
      base_sel = 2'd1; idx_sel = 2'd1; disp_sel = 2'd0;
      base_gen = 16'hFFFF; idx_src = 16'h0002; seg_data = 16'h0000;
      issue("R3 ea wrap");
      check("R3 ea wrapped", {16'd0, out_ea}, 32'h0001);
      base_sel = 2'd0; idx_sel = 2'd0; disp_sel = 2'd2; disp = 16'h0020; seg_data = 16'hFFFF;
      issue("R7 pa wrap");
      check("R7 pa wrapped", {12'd0, out_pa}, 32'h00010);
   endtask

   task automatic t_hold();
      logic [15:0] ea_h;
      logic [19:0] pa_h;
      ea_h = out_ea; pa_h = out_pa;
      base_sel = 2'd2; idx_sel = 2'd2; disp_sel = 2'd1; disp = 16'h7777;
      base_frame = 16'h1357; idx_dst = 16'h2468; seg_stack = 16'h0F0F;
      @(negedge clk);
      base_gen = 16'h9999; ovr_en = 1'b1; ovr_seg = 2'd1;
      @(negedge clk);
      check("R8 ea held", {16'd0, out_ea}, {16'd0, ea_h});
      check("R8 pa held", {12'd0, out_pa}, {12'd0, pa_h});
      check("R2 idle", {31'd0, out_valid}, 32'd0);
      ovr_en = 1'b0;
   endtask

   task automatic t_back_to_back();
      base_sel = 2'd0; idx_sel = 2'd0; disp_sel = 2'd2; seg_data = 16'h0100;
      disp = 16'h0001;
      in_valid = 1'b1;
      @(posedge clk); @(negedge clk);
      check("R2 b2b first", {31'd0, out_valid}, 32'd1);
      check("R7 b2b first pa", {12'd0, out_pa}, 32'h01001);
      disp = 16'h0002;
      @(posedge clk); @(negedge clk);
      in_valid = 1'b0;
      check("R2 b2b second", {31'd0, out_valid}, 32'd1);
      check("R7 b2b second pa", {12'd0, out_pa}, 32'h01002);
      @(negedge clk);
      check("R2 b2b drop", {31'd0, out_valid}, 32'd0);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_direct();
      t_short_disp();
      t_combos();
      t_segments();
      t_wrap();
      t_hold();
      t_back_to_back();
      done = 1'b1;
      finish_run();
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual hung expected finished");
         finish_run();
      end
   end
endmodule